// File: doc/BRIEF.md
# Programmable AND-OR Product-Term Array

This block is the sum-of-products core of a small programmable logic device. Sixteen logic signals enter it: eight dedicated inputs and eight signals that come back from output pins or output-cell feedback. Each signal is expanded into a true line and a complement line, which gives 32 array lines. Sixty-four product terms are each formed as an AND over whichever of those lines a connection bitmap selects. The terms are then gathered, eight to an output, into eight OR sums plus one auxiliary term per output, which the downstream output cells use either as an extra sum term or as an output-enable.

The connection bitmap sits in an on-block memory of 64 rows of 32 cells, one row per product term. It is written one row at a time through a word-wide port that carries a row address, and any row can be read back through a separate read address for verification. A cleared cell means "not connected". Reset erases every cell. A global device mode, together with a per-output registered-select bit, decides whether the eighth term of each output's group joins the OR or is left out for the output cell to use as an enable. The evaluation path from the signal inputs to the sums is purely combinational.

Top module: `sop_term_array`

## Requirements
- R1: After reset every connection cell reads 0 (open) on `cfg_rdata`, for any row selected by `cfg_rd_row`.
- R2: When `cfg_we` is 1 at a rising clock edge, row `cfg_row` takes the value of `cfg_wdata`; from the next cycle on, that row reads back this value and all other rows keep their contents.
- R3: Array line 2*i carries `sig_in[i]` and line 2*i+1 carries its complement; a row whose only set bit is 2*i yields a term equal to `sig_in[i]`, and a row whose only set bit is 2*i+1 yields `~sig_in[i]`.
- R4: Product term t (`pterm[t]`) is 1 exactly when every line whose bit is set in row t is 1, so a term with several connections is their AND.
- R5: A term whose row connects both the true and the complement line of any one signal is 0 for every input pattern.
- R6: A term whose row is all zero (every cell open) is 1 for every input pattern.
- R7: Output g is served by terms 8*g through 8*g+7; `aux_term[g]` always equals term 8*g+7.
- R8: With `dev_mode` equal to 2'b00 (simple) or 2'b11 (treated as simple), `or_sum[g]` is the OR of all eight terms of group g.
- R9: With `dev_mode` equal to 2'b01 (complex), `or_sum[g]` is the OR of terms 8*g through 8*g+6 only; term 8*g+7 has no effect on it.
- R10: With `dev_mode` equal to 2'b10 (registered), `or_sum[g]` is the OR of all eight terms when `reg_sel[g]` is 1 and of the first seven when it is 0.
- R11: `pterm`, `or_sum` and `aux_term` follow a change of `sig_in`, `dev_mode` or `reg_sel` within the same cycle, without waiting for a clock edge.
- R12: While `cfg_we` is 0, changes on `cfg_row` and `cfg_wdata` leave every row and every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the connection memory |
| rst_n | input | 1 | Asynchronous active-low reset; erases all cells |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 6 | Row (product term) address for a write |
| cfg_wdata | input | 32 | Connection cells for the addressed row; bit k set connects line k |
| cfg_rd_row | input | 6 | Row address for read-back |
| cfg_rdata | output | 32 | Contents of row `cfg_rd_row` |
| dev_mode | input | 2 | Global mode: 00 simple, 01 complex, 10 registered, 11 as simple |
| reg_sel | input | 8 | Per output, selects registered allocation in registered mode |
| sig_in | input | 16 | Dedicated inputs and feedback signals |
| pterm | output | 64 | Value of every product term |
| or_sum | output | 8 | OR sum of each output group |
| aux_term | output | 8 | Eighth term of each output group |

## Verification
On every cycle the assertions check that a row write lands and is visible at the read port, that rows without a strobe hold still, that a term with a contradictory pair of connections is false, that an all-open term is true, and that in each group the eighth term can force the sum high only when the group uses all eight terms and cannot when it uses seven. The bench alone shows the erased state after reset, the ordering of true and complement lines, the mapping of term indices onto output groups, the exact mode decoding including the reserved code, and that the outputs respond within the cycle in which the inputs change; it compares every term and every sum against an independent model of the bitmap over directed and pseudo-random configurations.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

    typedef enum logic [1:0] {
        MODE_SIMPLE     = 2'b00,
        MODE_COMPLEX    = 2'b01,
        MODE_REGISTERED = 2'b10,
        MODE_RESERVED   = 2'b11
    } dev_mode_e;

    // Decide whether a group ORs all of its terms or keeps the last one aside.
    function automatic logic uses_all_terms(input logic [1:0] mode, input logic reg_sel);
        logic full;
        case (dev_mode_e'(mode))
            MODE_SIMPLE:     full = 1'b1;
            MODE_COMPLEX:    full = 1'b0;
            MODE_REGISTERED: full = reg_sel;
            default:         full = 1'b1;
        endcase
        return full;
    endfunction

endpackage

// File: rtl/sop_line_drive.sv
module sop_line_drive #(
    parameter int N_SIG = 16
) (
    input  logic [N_SIG-1:0]   sig,
    output logic [2*N_SIG-1:0] lines
);

    // Even line: true polarity, odd line: complement.
    for (genvar i = 0; i < N_SIG; i++) begin : g_pair
        assign lines[2*i]   = sig[i];
        assign lines[2*i+1] = ~sig[i];
    end

endmodule

// File: rtl/sop_pt_row.sv
module sop_pt_row #(
    parameter int N_SIG = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2*N_SIG-1:0] wr_data,
    input  logic [2*N_SIG-1:0] lines,
    output logic [2*N_SIG-1:0] cells,
    output logic               term
);

    localparam int N_LINES = 2 * N_SIG;

    typedef struct packed {
        logic [N_LINES-1:0] cells;
    } row_state_t;

    row_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cells = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cells = st_q.cells;

    // An open cell forces its line to 1 in the AND.
    assign term = &(lines | ~st_q.cells);

    // Flags a signal connected in both polarities (used by the checks below).
    logic [N_SIG-1:0] pair_hit;
    for (genvar i = 0; i < N_SIG; i++) begin : g_pair_hit
        assign pair_hit[i] = st_q.cells[2*i] & st_q.cells[2*i+1];
    end

    a_r2_row_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cells == $past(wr_data)));

    a_r12_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cells));

    a_r5_contradiction_false: assert property (@(posedge clk) disable iff (!rst_n)
        (|pair_hit) |-> !term);

    a_r6_open_true: assert property (@(posedge clk) disable iff (!rst_n)
        (cells == '0) |-> term);

endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
    parameter int TERMS_PER_OUT = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TERMS_PER_OUT-1:0] terms,
    input  logic [1:0]               mode,
    input  logic                     reg_sel,
    output logic                     sum,
    output logic                     aux
);

    import sop_array_pkg::*;

    localparam int LAST = TERMS_PER_OUT - 1;

    logic full;

    always_comb begin
        full = uses_all_terms(mode, reg_sel);
        sum  = full ? (|terms) : (|terms[LAST-1:0]);
        aux  = terms[LAST];
    end

    // R9/R10: with seven-term allocation, the last term alone cannot raise the sum.
    a_r9_last_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b01) && !(|terms[LAST-1:0])) |-> !sum);

    // R8: in simple mode the last term raises the sum on its own.
    a_r8_last_counts: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b00) && terms[LAST]) |-> sum);

endmodule

// File: rtl/sop_term_array.sv
module sop_term_array #(
    parameter  int N_SIG         = 16,
    parameter  int N_OUT         = 8,
    parameter  int TERMS_PER_OUT = 8,
    localparam int N_LINES       = 2 * N_SIG,
    localparam int N_TERMS       = N_OUT * TERMS_PER_OUT,
    localparam int ROW_AW        = $clog2(N_TERMS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ROW_AW-1:0]  cfg_row,
    input  logic [N_LINES-1:0] cfg_wdata,
    input  logic [ROW_AW-1:0]  cfg_rd_row,
    output logic [N_LINES-1:0] cfg_rdata,
    input  logic [1:0]         dev_mode,
    input  logic [N_OUT-1:0]   reg_sel,
    input  logic [N_SIG-1:0]   sig_in,
    output logic [N_TERMS-1:0] pterm,
    output logic [N_OUT-1:0]   or_sum,
    output logic [N_OUT-1:0]   aux_term
);

    logic [N_LINES-1:0] lines;
    logic [N_TERMS-1:0] row_we;
    logic [N_LINES-1:0] row_cells [N_TERMS];

    sop_line_drive #(.N_SIG(N_SIG)) u_lines (
        .sig   (sig_in),
        .lines (lines)
    );

    for (genvar t = 0; t < N_TERMS; t++) begin : g_row
        assign row_we[t] = cfg_we && (cfg_row == ROW_AW'(t));

        sop_pt_row #(.N_SIG(N_SIG)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (row_we[t]),
            .wr_data (cfg_wdata),
            .lines   (lines),
            .cells   (row_cells[t]),
            .term    (pterm[t])
        );
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        sop_or_group #(.TERMS_PER_OUT(TERMS_PER_OUT)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .terms   (pterm[g*TERMS_PER_OUT +: TERMS_PER_OUT]),
            .mode    (dev_mode),
            .reg_sel (reg_sel[g]),
            .sum     (or_sum[g]),
            .aux     (aux_term[g])
        );
    end

    assign cfg_rdata = row_cells[cfg_rd_row];

    // R2: a written row shows up on the read port one cycle later.
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_rd_row == cfg_row)) |=>
            (!$stable(cfg_rd_row) || (cfg_rdata == $past(cfg_wdata))));

    a_r2_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we));

endmodule

// File: tb/sop_term_array_tb.sv
module sop_term_array_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [5:0]  cfg_row;
    logic [31:0] cfg_wdata;
    logic [5:0]  cfg_rd_row;
    logic [31:0] cfg_rdata;
    logic [1:0]  dev_mode;
    logic [7:0]  reg_sel;
    logic [15:0] sig_in;
    logic [63:0] pterm;
    logic [7:0]  or_sum;
    logic [7:0]  aux_term;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_term_array u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_row    (cfg_row),
        .cfg_wdata  (cfg_wdata),
        .cfg_rd_row (cfg_rd_row),
        .cfg_rdata  (cfg_rdata),
        .dev_mode   (dev_mode),
        .reg_sel    (reg_sel),
        .sig_in     (sig_in),
        .pterm      (pterm),
        .or_sum     (or_sum),
        .aux_term   (aux_term)
    );

    // Scoreboard item: which output to look at and what it must hold.
    typedef struct {
        string       req;
        int          sel;   // 0: {aux_term,or_sum}, 1: cfg_rdata, 2: pterm
        logic [63:0] exp;
    } item_t;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;
    logic [31:0] mdl [64];
    logic [31:0] rng = 32'h1D2C_3B4A;

    function automatic logic [63:0] model_terms(input logic [15:0] s);
        logic [63:0] r;
        logic [31:0] ln;
        for (int i = 0; i < 16; i++) begin
            ln[2*i]   = s[i];
            ln[2*i+1] = ~s[i];
        end
        for (int t = 0; t < 64; t++) begin
            r[t] = ((ln & mdl[t]) == mdl[t]);
        end
        return r;
    endfunction

    function automatic logic [15:0] model_outs(input logic [15:0] s, input logic [1:0] m,
                                               input logic [7:0] rs);
        logic [63:0] tv;
        logic [7:0]  grp;
        logic [7:0]  sm;
        logic [7:0]  ax;
        logic        full;
        tv = model_terms(s);
        for (int g = 0; g < 8; g++) begin
            grp   = tv[g*8 +: 8];
            full  = (m == 2'b00) || (m == 2'b11) || ((m == 2'b10) && rs[g]);
            sm[g] = full ? (|grp) : (|grp[6:0]);
            ax[g] = grp[7];
        end
        return {ax, sm};
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Monitor: a quarter period after each falling edge, well before the next rise.
    initial begin
        item_t       it;
        logic [63:0] obs;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                case (it.sel)
                    0:       obs = {48'b0, aux_term, or_sum};
                    1:       obs = {32'b0, cfg_rdata};
                    default: obs = pterm;
                endcase
                n_checks++;
                if (obs !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s sel=%0d: actual=%h expected=%h", it.req, it.sel, obs, it.exp);
                end
            end
        end
    end

    task automatic apply(input logic [15:0] s, input logic [1:0] m, input logic [7:0] rs,
                         input string req);
        @(negedge clk);
        sig_in   = s;
        dev_mode = m;
        reg_sel  = rs;
        sb_q.push_back('{req, 2, model_terms(s)});
        sb_q.push_back('{req, 0, {48'b0, model_outs(s, m, rs)}});
    endtask

    task automatic read_check(input int row, input string req);
        @(negedge clk);
        cfg_rd_row = 6'(row);
        sb_q.push_back('{req, 1, {32'b0, mdl[row]}});
    endtask

    task automatic write_row(input int row, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_row   = 6'(row);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
        mdl[row]  = data;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        cfg_we     = 1'b0;
        cfg_row    = '0;
        cfg_wdata  = '0;
        cfg_rd_row = '0;
        dev_mode   = 2'b00;
        reg_sel    = '0;
        sig_in     = '0;
        for (int t = 0; t < 64; t++) mdl[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: erased after reset; R6: open terms are true.
        read_check(0, "R1");
        read_check(21, "R1");
        read_check(63, "R1");
        apply(16'h0000, 2'b00, 8'h00, "R6");
        apply(16'hA5C3, 2'b01, 8'h00, "R6");

        // R5: every row connected to both polarities of signal 0.
        for (int r = 0; r < 64; r++) write_row(r, 32'h0000_0003);
        apply(16'h0000, 2'b00, 8'h00, "R5");
        apply(16'hFFFF, 2'b00, 8'h00, "R5");

        // R3: line order, true at 2*i, complement at 2*i+1 (signal 3).
        write_row(0, 32'h1 << 6);
        write_row(1, 32'h1 << 7);
        apply(16'h0008, 2'b00, 8'h00, "R3");
        apply(16'h0000, 2'b00, 8'h00, "R3");

        // R4: sig0 AND ~sig1 AND sig15 on term 9.
        write_row(9, (32'h1 << 0) | (32'h1 << 3) | (32'h1 << 30));
        apply(16'h8001, 2'b00, 8'h00, "R4");
        apply(16'h8003, 2'b00, 8'h00, "R4");
        apply(16'h0001, 2'b00, 8'h00, "R4");

        // R7: only the eighth term of group 5 is open.
        write_row(47, 32'h0);
        apply(16'h0000, 2'b00, 8'h00, "R7");
        // R9: complex mode drops it from the sum; R11: same-cycle response.
        apply(16'h0000, 2'b01, 8'h00, "R9");
        apply(16'h0008, 2'b01, 8'h00, "R11");
        // R8: simple and reserved codes use all eight.
        apply(16'h0000, 2'b00, 8'hFF, "R8");
        apply(16'h0000, 2'b11, 8'h00, "R8");
        // R10: registered mode follows reg_sel per output.
        apply(16'h0000, 2'b10, 8'h20, "R10");
        apply(16'h0000, 2'b10, 8'hDF, "R10");

        // R2: read back written rows, neighbours untouched.
        read_check(0, "R2");
        read_check(1, "R2");
        read_check(9, "R2");
        read_check(47, "R2");
        write_row(63, 32'hDEAD_BEEF);
        read_check(63, "R2");
        read_check(62, "R2");

        // R12: address and data move without the strobe.
        @(negedge clk);
        cfg_row   = 6'd5;
        cfg_wdata = 32'hFFFF_FFFF;
        read_check(5, "R12");
        apply(16'h1234, 2'b00, 8'h00, "R12");
        cfg_wdata = '0;

        // Pseudo-random sparse rows and inputs across all modes.
        for (int k = 0; k < 24; k++) begin
            logic [31:0] a;
            logic [31:0] b;
            rng = next_rng(rng); a = rng;
            rng = next_rng(rng); b = rng;
            rng = next_rng(rng);
            write_row(int'(a[5:0]), a & b & rng);
            rng = next_rng(rng);
            apply(rng[15:0], 2'(k), rng[23:16], "R4");
            read_check(int'(a[5:0]), "R2");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule